// File: doc/BRIEF.md
# Cache Maintenance and Debug Register Unit

This unit sits between a processor's coprocessor register path and the tag arrays of a split instruction/data cache. The processor writes or reads registers named by a 12-bit operation ID. Maintenance IDs become single-cycle invalidate commands sent to the caches. Debug IDs give raw 32-bit access to individual tag entries, which are addressed through a debug index register held in the unit. Two lockdown registers are kept as plain 32-bit storage.

The data cache is write-through, so clean operations have nothing to write back. They are accepted and complete at once. Combined clean-and-invalidate operations reduce to the matching invalidate. Set/way operands and the debug index share one layout: the way sits in the top bits and the line index sits just above the byte offset within a line. Every accepted maintenance write ends with a one-cycle completion pulse, raised once every cache it addressed has acknowledged its command. Software waits for that pulse before it issues the next maintenance operation.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset, reads of ID 0xF00, 0x900 and 0x901 return zero, and `ic_cmd_valid`, `dc_cmd_valid`, `maint_done` and `cp_rvalid` are low.
- R2: A write to ID 0xF00 stores the full 32-bit value as the debug index. A read strobe on any ID sets `cp_rvalid` high in the next cycle only, with `cp_rdata` carrying the result; a read of 0xF00 returns the stored index.
- R3: Writes to ID 0x900 (data lockdown) and ID 0x901 (instruction lockdown) each store the full 32-bit value, and reads return it unchanged.
- R4: Reads of any ID other than 0xF00, 0x900, 0x901, 0xF10 and 0xF20 return zero, including the maintenance IDs. A write to an unlisted ID changes no register and issues no command.
- R5: A write to 0x760, 0x761 or 0x762 pulses `dc_cmd_valid` for exactly one cycle, in the cycle after the write. `dc_cmd_op` is 0 for the whole cache, 1 for by-address and 2 for by-set/way. `dc_cmd_addr` equals the written value, `dc_cmd_way` equals value bits [31:30] and `dc_cmd_line` equals value bits [9:5].
- R6: A write to 0x770 pulses `ic_cmd_valid` and `dc_cmd_valid` (op 0) in the same cycle, the cycle after the write.
- R7: Writes to 0x7A0, 0x7A1, 0x7A2 and 0x7A3 issue no command to either cache, and `maint_done` is high in the cycle after the write.
- R8: Writes to 0x7E0, 0x7E1 and 0x7E2 issue the data-cache invalidate with op 0, 1 and 2 respectively, carrying the operand fields as in R5.
- R9: An ack input that is high while its cache has an unretired command retires it. `maint_done` is high for exactly one cycle, the cycle after the last outstanding ack. An ack with nothing outstanding is ignored.
- R10: A write to 0xF10 or 0xF20 raises `itag_we` or `dtag_we` in that same cycle, with `tag_wdata` equal to the written value. `tag_way` always equals debug index bits [31:30] and `tag_line` always equals index bits [9:5].
- R11: A read of 0xF10 or 0xF20 returns, one cycle later, the instruction or data tag word at the entry the index selects. Index bits [4:2] and the other bits outside way and line do not change the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_wr | input | 1 | Register write strobe |
| cp_rd | input | 1 | Register read strobe |
| cp_id | input | 12 | Operation / register ID |
| cp_wdata | input | 32 | Write value |
| cp_rdata | output | 32 | Read result, valid with cp_rvalid |
| cp_rvalid | output | 1 | Read result valid, one cycle after cp_rd |
| maint_done | output | 1 | One-cycle completion pulse of a maintenance write |
| ic_cmd_valid | output | 1 | Instruction cache invalidate-all command pulse |
| ic_cmd_ack | input | 1 | Instruction cache command acknowledge |
| dc_cmd_valid | output | 1 | Data cache invalidate command pulse |
| dc_cmd_op | output | 2 | 0 whole cache, 1 by address, 2 by set/way |
| dc_cmd_addr | output | 32 | Raw operand (address for op 1) |
| dc_cmd_way | output | 2 | Way field of the operand |
| dc_cmd_line | output | 5 | Line index field of the operand |
| dc_cmd_ack | input | 1 | Data cache command acknowledge |
| tag_way | output | 2 | Tag debug entry way, from debug index |
| tag_line | output | 5 | Tag debug entry line, from debug index |
| tag_wdata | output | 32 | Raw tag value to write |
| itag_we | output | 1 | Instruction tag array write enable |
| itag_rdata | input | 32 | Instruction tag array read data at tag_way/tag_line |
| dtag_we | output | 1 | Data tag array write enable |
| dtag_rdata | input | 32 | Data tag array read data at tag_way/tag_line |

## Verification
A corrupted debug index shows up immediately on `tag_way`/`tag_line`, and so selects the wrong tag array entry. It appears on `cp_rdata` one cycle after the next tag or index read. A lost or stuck outstanding-command flag shows at `maint_done`: the pulse either comes a cycle early, before the last ack, or never comes at all. A wrong operand field latch shows on `dc_cmd_op`, `dc_cmd_way` or `dc_cmd_line` in the very pulse cycle. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/cmu_pkg.sv
// Shared constants and types of the cache maintenance unit.
// Assumes 12-bit operation IDs; the ID values are software-visible.
package cmu_pkg;

    localparam logic [11:0] ID_DBG_INDEX = 12'hF00;
    localparam logic [11:0] ID_ITAG      = 12'hF10;
    localparam logic [11:0] ID_DTAG      = 12'hF20;
    localparam logic [11:0] ID_LOCK_D    = 12'h900;
    localparam logic [11:0] ID_LOCK_I    = 12'h901;
    localparam logic [11:0] ID_DINV_ALL  = 12'h760;
    localparam logic [11:0] ID_DINV_ADDR = 12'h761;
    localparam logic [11:0] ID_DINV_SW   = 12'h762;
    localparam logic [11:0] ID_INV_BOTH  = 12'h770;
    localparam logic [11:0] ID_CLN_ALL   = 12'h7A0;
    localparam logic [11:0] ID_CLN_ADDR  = 12'h7A1;
    localparam logic [11:0] ID_CLN_SW    = 12'h7A2;
    localparam logic [11:0] ID_CLN_TEST  = 12'h7A3;
    localparam logic [11:0] ID_CINV_ALL  = 12'h7E0;
    localparam logic [11:0] ID_CINV_ADDR = 12'h7E1;
    localparam logic [11:0] ID_CINV_SW   = 12'h7E2;

    // Data cache invalidate scope, as seen on dc_cmd_op
    typedef enum logic [1:0] {
        DOP_ALL    = 2'd0,
        DOP_ADDR   = 2'd1,
        DOP_SETWAY = 2'd2
    } dop_e;

    // Read source selection
    typedef enum logic [2:0] {
        RSEL_ZERO,
        RSEL_INDEX,
        RSEL_LOCK_D,
        RSEL_LOCK_I,
        RSEL_ITAG,
        RSEL_DTAG
    } rsel_e;

    // Decoded write actions for one cycle
    typedef struct packed {
        logic wr_index;
        logic wr_lock_d;
        logic wr_lock_i;
        logic wr_itag;
        logic wr_dtag;
        logic start_i;
        logic start_d;
        logic accept;
        dop_e dop;
    } wdec_t;

endpackage

// File: rtl/cmu_decode.sv
// ID decoder: turns the operation ID and write strobe into per-cycle
// actions and a read source select. Purely combinational.
// Assumes clean operations are no-ops because the data cache is write-through.
module cmu_decode
    import cmu_pkg::*;
(
    input  logic        cp_wr,
    input  logic [11:0] cp_id,
    output wdec_t       wd,
    output rsel_e       rsel
);

    // Map each ID to its write action and read source
    always_comb begin
        wd   = '0;
        rsel = RSEL_ZERO;
        case (cp_id)
            ID_DBG_INDEX: begin
                wd.wr_index = cp_wr;
                rsel        = RSEL_INDEX;
            end
            ID_LOCK_D: begin
                wd.wr_lock_d = cp_wr;
                rsel         = RSEL_LOCK_D;
            end
            ID_LOCK_I: begin
                wd.wr_lock_i = cp_wr;
                rsel         = RSEL_LOCK_I;
            end
            ID_ITAG: begin
                wd.wr_itag = cp_wr;
                rsel       = RSEL_ITAG;
            end
            ID_DTAG: begin
                wd.wr_dtag = cp_wr;
                rsel       = RSEL_DTAG;
            end
            ID_DINV_ALL, ID_CINV_ALL: begin
                wd.start_d = cp_wr;
                wd.accept  = cp_wr;
                wd.dop     = DOP_ALL;
            end
            ID_DINV_ADDR, ID_CINV_ADDR: begin
                wd.start_d = cp_wr;
                wd.accept  = cp_wr;
                wd.dop     = DOP_ADDR;
            end
            ID_DINV_SW, ID_CINV_SW: begin
                wd.start_d = cp_wr;
                wd.accept  = cp_wr;
                wd.dop     = DOP_SETWAY;
            end
            ID_INV_BOTH: begin
                wd.start_i = cp_wr;
                wd.start_d = cp_wr;
                wd.accept  = cp_wr;
                wd.dop     = DOP_ALL;
            end
            ID_CLN_ALL, ID_CLN_ADDR, ID_CLN_SW, ID_CLN_TEST: begin
                wd.accept = cp_wr;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cmu_regs.sv
// Register file of the unit: debug index, two lockdown words and the
// registered read-back path. Assumes tag read data is valid in the
// cycle the read strobe is high (asynchronous tag read port).
module cmu_regs
    import cmu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wdec_t         wd,
    input  rsel_e         rsel,
    input  logic          cp_rd,
    input  logic [DW-1:0] cp_wdata,
    input  logic [DW-1:0] itag_rdata,
    input  logic [DW-1:0] dtag_rdata,
    output logic [DW-1:0] dbg_index,
    output logic [DW-1:0] cp_rdata,
    output logic          cp_rvalid
);

    logic [DW-1:0] lock_d_q;
    logic [DW-1:0] lock_i_q;
    logic [DW-1:0] rd_mux;

    // Storage registers written by their own IDs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_index <= '0;
            lock_d_q  <= '0;
            lock_i_q  <= '0;
        end else begin
            if (wd.wr_index)  dbg_index <= cp_wdata;
            if (wd.wr_lock_d) lock_d_q  <= cp_wdata;
            if (wd.wr_lock_i) lock_i_q  <= cp_wdata;
        end
    end

    // Read source selection
    always_comb begin
        case (rsel)
            RSEL_INDEX:  rd_mux = dbg_index;
            RSEL_LOCK_D: rd_mux = lock_d_q;
            RSEL_LOCK_I: rd_mux = lock_i_q;
            RSEL_ITAG:   rd_mux = itag_rdata;
            RSEL_DTAG:   rd_mux = dtag_rdata;
            default:     rd_mux = '0;
        endcase
    end

    // Read result register, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_rdata  <= '0;
            cp_rvalid <= 1'b0;
        end else begin
            cp_rvalid <= cp_rd;
            if (cp_rd) cp_rdata <= rd_mux;
        end
    end

    // R4: the index only moves on its own write
    p_index_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wd.wr_index |=> $stable(dbg_index));

    // R2: a read strobe yields a valid result in the next cycle
    p_rvalid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cp_rd |=> cp_rvalid);

endmodule

// File: rtl/cmu_chan.sv
// Command channels: one per cache. A start issues a one-cycle command
// pulse in the next cycle and marks the channel outstanding until the
// cache acknowledges. Assumes the processor waits for completion before
// starting another command.
module cmu_chan #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] start,
    input  logic [NCH-1:0] ack,
    output logic [NCH-1:0] valid,
    output logic [NCH-1:0] pend
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic v_q;
        logic p_q;

        // Issue pulse and outstanding flag of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                p_q <= 1'b0;
            end else begin
                v_q <= start[c];
                p_q <= start[c] | (p_q & ~ack[c]);
            end
        end

        assign valid[c] = v_q;
        assign pend[c]  = p_q;

        // R5: a command pulse lasts one cycle
        p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q && !start[c]) |=> !v_q);

        // R9: an ack on an outstanding command retires it
        p_ack_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (p_q && ack[c] && !start[c]) |=> !p_q);
    end

endmodule

// File: rtl/cache_maint_unit.sv
// Cache maintenance and debug register unit (top).
// Decodes coprocessor IDs into cache invalidate commands, tag debug
// accesses and register accesses, and signals completion of each
// maintenance write. Assumes one outstanding maintenance write at a time.
module cache_maint_unit
    import cmu_pkg::*;
#(
    parameter int  DW         = 32,
    parameter int  WAYS       = 4,
    parameter int  LINES      = 32,
    parameter int  LINE_BYTES = 32,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int LINE_W     = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr,
    input  logic              cp_rd,
    input  logic [11:0]       cp_id,
    input  logic [DW-1:0]     cp_wdata,
    output logic [DW-1:0]     cp_rdata,
    output logic              cp_rvalid,
    output logic              maint_done,
    output logic              ic_cmd_valid,
    input  logic              ic_cmd_ack,
    output logic              dc_cmd_valid,
    output logic [1:0]        dc_cmd_op,
    output logic [DW-1:0]     dc_cmd_addr,
    output logic [WAY_W-1:0]  dc_cmd_way,
    output logic [LINE_W-1:0] dc_cmd_line,
    input  logic              dc_cmd_ack,
    output logic [WAY_W-1:0]  tag_way,
    output logic [LINE_W-1:0] tag_line,
    output logic [DW-1:0]     tag_wdata,
    output logic              itag_we,
    input  logic [DW-1:0]     itag_rdata,
    output logic              dtag_we,
    input  logic [DW-1:0]     dtag_rdata
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int CH_I  = 0;
    localparam int CH_D  = 1;

    wdec_t          wd;
    rsel_e          rsel;
    logic [DW-1:0]  dbg_index;
    logic [1:0]     ch_start;
    logic [1:0]     ch_ack;
    logic [1:0]     ch_valid;
    logic [1:0]     ch_pend;
    dop_e           dop_q;
    logic [DW-1:0]  arg_q;
    logic           wait_q;

    cmu_decode u_decode (
        .cp_wr (cp_wr),
        .cp_id (cp_id),
        .wd    (wd),
        .rsel  (rsel)
    );

    cmu_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd         (wd),
        .rsel       (rsel),
        .cp_rd      (cp_rd),
        .cp_wdata   (cp_wdata),
        .itag_rdata (itag_rdata),
        .dtag_rdata (dtag_rdata),
        .dbg_index  (dbg_index),
        .cp_rdata   (cp_rdata),
        .cp_rvalid  (cp_rvalid)
    );

    assign ch_start[CH_I] = wd.start_i;
    assign ch_start[CH_D] = wd.start_d;
    assign ch_ack[CH_I]   = ic_cmd_ack;
    assign ch_ack[CH_D]   = dc_cmd_ack;

    cmu_chan #(.NCH(2)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ch_start),
        .ack   (ch_ack),
        .valid (ch_valid),
        .pend  (ch_pend)
    );

    // Data cache operand latch, loaded when a data command starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dop_q <= DOP_ALL;
            arg_q <= '0;
        end else if (wd.start_d) begin
            dop_q <= wd.dop;
            arg_q <= cp_wdata;
        end
    end

    assign ic_cmd_valid = ch_valid[CH_I];
    assign dc_cmd_valid = ch_valid[CH_D];
    assign dc_cmd_op    = dop_q;
    assign dc_cmd_addr  = arg_q;
    assign dc_cmd_way   = arg_q[DW-1 -: WAY_W];
    assign dc_cmd_line  = arg_q[OFF_W +: LINE_W];

    // Completion tracking across both caches
    always_ff @(posedge clk) begin
        if (!rst_n)          wait_q <= 1'b0;
        else if (wd.accept)  wait_q <= 1'b1;
        else if (maint_done) wait_q <= 1'b0;
    end

    assign maint_done = wait_q & ~|ch_pend;

    // Tag debug port: entry chosen by the debug index
    assign tag_way   = dbg_index[DW-1 -: WAY_W];
    assign tag_line  = dbg_index[OFF_W +: LINE_W];
    assign tag_wdata = cp_wdata;
    assign itag_we   = wd.wr_itag;
    assign dtag_we   = wd.wr_dtag;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (maint_done && !wd.accept) |=> !maint_done);

    // R7: clean operations send nothing to the caches
    p_clean_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd.accept && !wd.start_i && !wd.start_d) |=> (!ic_cmd_valid && !dc_cmd_valid));

    // R6: the instruction cache is only ever invalidated together with the data cache
    p_both_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ic_cmd_valid |-> dc_cmd_valid);

    // R10: at most one tag array is written per cycle
    p_tag_we_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({itag_we, dtag_we}));

endmodule

// File: tb/test_cache_maint_unit.sv
`timescale 1ns/1ps
module test_cache_maint_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_wr = 1'b0;
    logic        cp_rd = 1'b0;
    logic [11:0] cp_id = '0;
    logic [31:0] cp_wdata = '0;
    logic        ic_cmd_ack = 1'b0;
    logic        dc_cmd_ack = 1'b0;
    logic [31:0] cp_rdata, dc_cmd_addr, tag_wdata, itag_rdata, dtag_rdata;
    logic        cp_rvalid, maint_done, ic_cmd_valid, dc_cmd_valid, itag_we, dtag_we;
    logic [1:0]  dc_cmd_op, dc_cmd_way, tag_way;
    logic [4:0]  dc_cmd_line, tag_line;

    always #2.5 clk = ~clk;

    // Tag array stand-ins, written from the model's own expectations
    logic [31:0] imem [0:127];
    logic [31:0] dmem [0:127];
    assign itag_rdata = imem[{tag_line, tag_way}];
    assign dtag_rdata = dmem[{tag_line, tag_way}];

    cache_maint_unit i_cache_maint_unit (
        .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_id(cp_id),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid),
        .maint_done(maint_done), .ic_cmd_valid(ic_cmd_valid), .ic_cmd_ack(ic_cmd_ack),
        .dc_cmd_valid(dc_cmd_valid), .dc_cmd_op(dc_cmd_op), .dc_cmd_addr(dc_cmd_addr),
        .dc_cmd_way(dc_cmd_way), .dc_cmd_line(dc_cmd_line), .dc_cmd_ack(dc_cmd_ack),
        .tag_way(tag_way), .tag_line(tag_line), .tag_wdata(tag_wdata),
        .itag_we(itag_we), .itag_rdata(itag_rdata), .dtag_we(dtag_we), .dtag_rdata(dtag_rdata)
    );

    // Reference model state
    logic [31:0] m_idx, m_lkd, m_lki, m_rdata, m_arg;
    logic        m_rvalid, m_ival, m_dval, m_ipend, m_dpend, m_wait;
    int          m_op;
    int          vectors = 0;
    int          errors  = 0;
    string       phase   = "R1 reset state";

    function automatic int entry(input logic [31:0] v);
        return int'(v[9:5]) * 4 + int'(v[31:30]);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] id);
        case (id)
            12'hF00: return m_idx;
            12'h900: return m_lkd;
            12'h901: return m_lki;
            12'hF10: return imem[entry(m_idx)];
            12'hF20: return dmem[entry(m_idx)];
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_dinv(input logic [11:0] id);
        return id == 12'h760 || id == 12'h761 || id == 12'h762 || id == 12'h770 ||
               id == 12'h7E0 || id == 12'h7E1 || id == 12'h7E2;
    endfunction

    function automatic bit is_accept(input logic [11:0] id);
        return is_dinv(id) || (id >= 12'h7A0 && id <= 12'h7A3);
    endfunction

    // Behavioural model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_lkd = 0; m_lki = 0; m_rdata = 0; m_arg = 0;
            m_rvalid = 0; m_ival = 0; m_dval = 0; m_ipend = 0; m_dpend = 0;
            m_wait = 0; m_op = 0;
        end else begin
            automatic bit done_now = m_wait && !m_ipend && !m_dpend;
            automatic bit st_i = cp_wr && cp_id == 12'h770;
            automatic bit st_d = cp_wr && is_dinv(cp_id);
            m_rvalid = cp_rd;
            if (cp_rd) m_rdata = model_read(cp_id);
            if (cp_wr) begin
                case (cp_id)
                    12'hF00: m_idx = cp_wdata;
                    12'h900: m_lkd = cp_wdata;
                    12'h901: m_lki = cp_wdata;
                    12'hF10: imem[entry(m_idx)] = cp_wdata;
                    12'hF20: dmem[entry(m_idx)] = cp_wdata;
                    default: ;
                endcase
            end
            m_ival = st_i;
            m_dval = st_d;
            if (st_d) begin
                m_arg = cp_wdata;
                m_op  = int'(cp_id[1:0]);
            end
            m_ipend = st_i ? 1'b1 : (m_ipend && !ic_cmd_ack);
            m_dpend = st_d ? 1'b1 : (m_dpend && !dc_cmd_ack);
            if (cp_wr && is_accept(cp_id)) m_wait = 1;
            else if (done_now)             m_wait = 0;
        end
    end

    task automatic chk(input string sig, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%h expected=%h", phase, sig, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic compare_all();
        chk("cp_rvalid R2", 32'(cp_rvalid), 32'(m_rvalid));
        if (m_rvalid) chk("cp_rdata R2", cp_rdata, m_rdata);
        chk("ic_cmd_valid R6", 32'(ic_cmd_valid), 32'(m_ival));
        chk("dc_cmd_valid R5", 32'(dc_cmd_valid), 32'(m_dval));
        if (m_dval) begin
            chk("dc_cmd_op R5", 32'(dc_cmd_op), 32'(m_op));
            chk("dc_cmd_addr R5", dc_cmd_addr, m_arg);
            chk("dc_cmd_way R5", 32'(dc_cmd_way), 32'(m_arg[31:30]));
            chk("dc_cmd_line R5", 32'(dc_cmd_line), 32'(m_arg[9:5]));
        end
        chk("maint_done R9", 32'(maint_done), 32'(m_wait && !m_ipend && !m_dpend));
        chk("itag_we R10", 32'(itag_we), 32'(cp_wr && cp_id == 12'hF10));
        chk("dtag_we R10", 32'(dtag_we), 32'(cp_wr && cp_id == 12'hF20));
        chk("tag_way R10", 32'(tag_way), 32'(m_idx[31:30]));
        chk("tag_line R10", 32'(tag_line), 32'(m_idx[9:5]));
        if (cp_wr) chk("tag_wdata R10", tag_wdata, cp_wdata);
    endtask

    // One clock of stimulus, starting and ending at a falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [11:0] id,
                       input logic [31:0] wd, input logic ia, input logic da);
        cp_wr = wr; cp_rd = rd; cp_id = id; cp_wdata = wd;
        ic_cmd_ack = ia; dc_cmd_ack = da;
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] id, input logic [31:0] v);
        cyc(1'b1, 1'b0, id, v, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [11:0] id);
        cyc(1'b0, 1'b1, id, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic idle(input logic ia, input logic da);
        cyc(1'b0, 1'b0, 12'h000, 32'h0, ia, da);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int k = 0; k < 128; k++) begin
            imem[k] = 32'h1000_0000 + 32'(k) * 32'h0001_0101;
            dmem[k] = 32'h2000_0000 + 32'(k) * 32'h0103_0007;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1 reset state";
        idle(0, 0);
        rd(12'hF00); rd(12'h900); rd(12'h901); idle(0, 0);

        phase = "R2 debug index";
        wr(12'hF00, 32'hC000_01A4);
        rd(12'hF00); idle(0, 0);

        phase = "R3 lockdown";
        wr(12'h900, 32'hDEAD_BEEF);
        wr(12'h901, 32'h1234_5678);
        rd(12'h900); rd(12'h901); idle(0, 0);

        phase = "R4 unknown IDs";
        wr(12'h123, 32'hFFFF_FFFF);
        wr(12'hF30, 32'h5555_AAAA);
        rd(12'h123); rd(12'h760); rd(12'h7A0); rd(12'hF30);
        rd(12'h900); rd(12'hF00); idle(0, 0);

        phase = "R11 tag read";
        rd(12'hF10); rd(12'hF20);
        wr(12'hF00, 32'h4000_0060);
        rd(12'hF10); rd(12'hF20); idle(0, 0);

        phase = "R10 tag write";
        wr(12'hF10, 32'hAAAA_5555);
        wr(12'hF20, 32'h0F0F_F0F0);
        phase = "R11 word bits ignored";
        wr(12'hF00, 32'h4000_007C);
        rd(12'hF10); rd(12'hF20);
        wr(12'hF00, 32'h7FFF_FC1F);
        rd(12'hF20); idle(0, 0);

        phase = "R5 whole data invalidate";
        wr(12'h760, 32'h0000_0000);
        idle(0, 0); idle(0, 0); idle(0, 1); idle(0, 0); idle(0, 0);

        phase = "R5 address invalidate";
        wr(12'h761, 32'h0200_1234);
        idle(0, 1); idle(0, 0); idle(0, 0);

        phase = "R5 set-way invalidate";
        wr(12'h762, 32'h8000_0060);
        idle(0, 0); idle(0, 1); idle(0, 0);

        phase = "R6 invalidate both";
        wr(12'h770, 32'h0);
        idle(1, 0); idle(0, 0); idle(0, 1); idle(0, 0); idle(0, 0);
        wr(12'h770, 32'h0);
        idle(1, 1); idle(0, 0);

        phase = "R7 clean no-ops";
        wr(12'h7A0, 32'h0); idle(0, 0);
        wr(12'h7A1, 32'h0000_4000); idle(0, 0);
        wr(12'h7A2, 32'hC000_03E0); idle(0, 0);
        wr(12'h7A3, 32'h0); idle(0, 0);

        phase = "R8 clean and invalidate";
        wr(12'h7E0, 32'h0); idle(0, 1); idle(0, 0);
        wr(12'h7E1, 32'hFEDC_BA98); idle(0, 1); idle(0, 0);
        wr(12'h7E2, 32'h4000_03E0); idle(0, 0); idle(0, 1); idle(0, 0);

        phase = "R9 stray ack ignored";
        idle(1, 1); idle(0, 1);
        wr(12'h760, 32'h0);
        idle(0, 0); idle(0, 0); idle(0, 0); idle(0, 1); idle(0, 0); idle(0, 0);

        phase = "R4 unknown write no command";
        wr(12'h765, 32'h1111_2222); idle(0, 0); idle(0, 0);
        rd(12'hF00); idle(0, 0);

        summary();
    end

endmodule